// File: doc/BRIEF.md
# Dual Leading Bit Counter

This unit supports block floating point normalisation. From one 32-bit operand it produces two counts in a single operation. The first is the unsigned count of zero bits above the highest set bit. The second is the signed count of redundant sign bits, meaning the bits that repeat the sign bit directly below it. The two counts are packed together into one 32-bit result: the unsigned count sits in the lower half and the signed count in the upper half. Software can then use whichever half suits the data format without issuing a second operation.

Operands arrive on a valid/ready stream, and results leave on another valid/ready stream after a single register stage. Input is accepted on a clock edge when `in_valid` and `in_ready` are both high. The input side is ready whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and both flags stay frozen and no new operand is taken. A zero flag and a sign flag travel with each result.

Top module: `dual_lead_count`

## Requirements
- R1: Bits [15:0] of `out_result` hold the number of most significant zero bits of the operand, from 0 to 32.
- R2: For a non-zero operand whose bit 31 is 0, bits [31:16] hold the leading-zero count minus one.
- R3: For an operand whose bit 31 is 1, bits [31:16] hold the count of leading one bits minus one, and bits [15:0] hold 0.
- R4: An all-zero operand gives 32 in bits [15:0] and 31 in bits [31:16]. An all-ones operand gives 31 in bits [31:16] and 0 in bits [15:0].
- R5: An operand accepted at a clock edge appears on `out_result` with `out_valid` high just after the next edge.
- R6: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_zero` and `out_neg` all hold, and an offered operand is not taken.
- R7: `out_zero` is 1 exactly when the operand was all zeros. `out_neg` equals bit 31 of the operand.
- R8: After reset, `out_valid` is 0.
- R9: When a result is taken (`out_ready` high) and no new operand is offered, `out_valid` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand |
| in_data | input | 32 | Operand |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 32 | {signed count, unsigned count} |
| out_zero | output | 1 | Operand was zero |
| out_neg | output | 1 | Operand was negative |

## Verification
The bench sweeps every leading-zero position from 0 to 32, with several fill patterns below the leading one, and applies the complement of each operand to cover negative values. This catches an off-by-one between the two halves, and it catches a signed count that ignores the sign bit, which would report zeros where it should report ones. The zero and all-ones operands are checked separately. A design that lets the signed count wrap or saturate wrongly would show 32 or 0 instead of 31. A stalled output with a second operand waiting is also exercised, since a stage that overwrites its register while stalled would lose the first result.

// File: rtl/dlbc_pkg.sv
package dlbc_pkg;
  localparam int unsigned DEF_DATA_W = 32;

  typedef enum logic [1:0] {
    SGN_POS  = 2'b00,
    SGN_NEG  = 2'b01,
    SGN_ZERO = 2'b10
  } sign_class_t;
endpackage

// File: rtl/lead_zero_count.sv
module lead_zero_count #(
  parameter int unsigned W  = 32,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    logic hit;
    hit   = 1'b0;
    count = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && vec[i]) begin
        count = CW'(W - 1 - i);
        hit   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sign_run_fold.sv
module sign_run_fold #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] operand,
  output logic [W-2:0] folded
);
  // each bit below the MSB becomes 1 where it departs from the sign
  for (genvar g = 0; g < W - 1; g++) begin : g_fold
    assign folded[g] = operand[g] ^ operand[W-1];
  end
endmodule

// File: rtl/dual_lead_count.sv
module dual_lead_count
  import dlbc_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned UCW    = $clog2(DATA_W + 1),
  localparam int unsigned SCW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_zero,
  output logic              out_neg
);
  logic [UCW-1:0]    ucnt;
  logic [SCW-1:0]    scnt;
  logic [DATA_W-2:0] folded;
  logic              take;
  sign_class_t       cls;

  lead_zero_count #(.W(DATA_W)) i_ucount (
    .vec   (in_data),
    .count (ucnt)
  );

  sign_run_fold #(.W(DATA_W)) i_fold (
    .operand (in_data),
    .folded  (folded)
  );

  lead_zero_count #(.W(DATA_W - 1)) i_scount (
    .vec   (folded),
    .count (scnt)
  );

  always_comb begin
    if (in_data[DATA_W-1])  cls = SGN_NEG;
    else if (~|in_data)     cls = SGN_ZERO;
    else                    cls = SGN_POS;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b0;
      out_neg    <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_result <= {HALF_W'(scnt), HALF_W'(ucnt)};
        out_zero   <= (cls == SGN_ZERO);
        out_neg    <= (cls == SGN_NEG);
      end
    end
  end

  a_r1_low_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result[HALF_W-1:0] <= HALF_W'(DATA_W));

  a_r2_halves_offset: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_neg && !out_zero |->
      out_result[DATA_W-1:HALF_W] == out_result[HALF_W-1:0] - HALF_W'(1));

  a_r3_neg_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_neg |-> out_result[HALF_W-1:0] == '0);

  a_r4_zero_counts: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zero |->
      out_result[HALF_W-1:0] == HALF_W'(DATA_W) &&
      out_result[DATA_W-1:HALF_W] == HALF_W'(DATA_W - 1));

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_zero) && $stable(out_neg));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_zero && out_neg));

  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: tb/test_dual_lead_count.sv
module test_dual_lead_count;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_result;
  logic        out_zero;
  logic        out_neg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5ns clk = ~clk;

  dual_lead_count i_dual_lead_count (
    .clk, .rst_n, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_result, .out_zero, .out_neg
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bitlen(input logic [31:0] v);
    int n = 0;
    logic [31:0] t = v;
    while (t != 0) begin
      t = t >> 1;
      n++;
    end
    return n;
  endfunction

  function automatic logic [31:0] expect_res(input logic [31:0] v);
    int u, s;
    u = 32 - bitlen(v);
    if (v[31]) s = (32 - bitlen(~v)) - 1;
    else       s = (v == 0) ? 31 : u - 1;
    return {16'(s), 16'(u)};
  endfunction

  task automatic send(input logic [31:0] v, input string req);
    logic [31:0] e;
    e = expect_res(v);
    in_valid = 1'b1;
    in_data  = v;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R5", {31'd0, out_valid}, 32'd1);
    check(out_result === e, req, out_result, e);
    check(out_zero === (v == 0) && out_neg === v[31], "R7",
          {30'd0, out_zero, out_neg}, {30'd0, v == 0, v[31]});
  endtask

  initial begin
    #2ms;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, lfsr;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(out_valid === 1'b0, "R8", {31'd0, out_valid}, 32'd0);

    // R4 corner operands
    send(32'h0000_0000, "R4");
    send(32'hFFFF_FFFF, "R4");
    send(32'h8000_0000, "R3");
    send(32'h7FFF_FFFF, "R2");

    // R1 / R2 / R3 sweep over every leading-zero position and fills
    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k <= 32; k++) begin
      for (int f = 0; f < 4; f++) begin
        logic [31:0] top, fill, x;
        top  = (k == 32) ? 32'd0 : (32'h8000_0000 >> k);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        case (f)
          0: fill = 32'd0;
          1: fill = top - 32'd1;
          2: fill = (top - 32'd1) & 32'h5555_5555;
          default: fill = (top - 32'd1) & lfsr;
        endcase
        x = top | fill;
        send(x, (k == 0) ? "R3" : "R1");
        send(~x, "R3");
      end
    end

    // R9: after a taken result with no new operand, valid falls
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R9", {31'd0, out_valid}, 32'd0);

    // R6: stall with a second operand waiting
    a = 32'h0001_2345;
    b = 32'hFFF0_0000;
    out_ready = 1'b0;
    send(a, "R1");
    check(in_ready === 1'b0, "R6", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b1;
    in_data  = b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b1 && out_result === expect_res(a), "R6",
          out_result, expect_res(a));
    check(in_ready === 1'b0, "R6", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    #1ns;
    check(in_ready === 1'b1, "R6", {31'd0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_result === expect_res(b), "R6",
          out_result, expect_res(b));
    check(out_neg === 1'b1 && out_zero === 1'b0, "R7",
          {30'd0, out_zero, out_neg}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R9", {31'd0, out_valid}, 32'd0);

    // R8: reset in the middle of a held result
    out_ready = 1'b0;
    send(32'h0000_00F0, "R2");
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R8", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    out_ready = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule